// File: doc/BRIEF.md
# DMA Byte-Stream to Wide-Memory Bridge

This block sits between an external DMA engine that moves one byte per transfer and a memory port that moves 64-bit words. A single active-low request output tells the DMA engine whether it may move another byte. What that request means depends on a 2-bit mode that is loaded together with a start address and a byte-order bit.

In read mode the bridge fetches words from memory on its own. It starts at the loaded address and steps the address once per completed word. Fetched words go into a small prefetch queue. The bridge then hands them to the DMA engine one byte at a time.

In write mode the bridge collects incoming bytes into a 64-bit word. Each completed word goes into a queue, and the queued words are written to memory at consecutive addresses. Idle and block-move modes keep the DMA engine stalled.

The memory side is a single-word request/acknowledge handshake. A word counts as done in the cycle where both the request and the acknowledge are high.

Top module: `dma_byte_bridge`

## Requirements
- R1: A pulse on `modeWr` loads `modeSel`, `startAddr` and `byteOrder`. The modes are coded as follows: 2'b00 is idle, 2'b01 is read, 2'b10 is write and 2'b11 is block move.
- R2: In idle and block-move modes, `dreqN` stays high and `memReq` stays low. Bytes strobed in with `wrStrobe` are discarded, so no word is ever written to memory from them.
- R3: With byte order 0, the first byte of a word sits in bits 7:0 and each following byte goes one lane higher. With byte order 1, the first byte sits in bits 63:56 and each following byte goes one lane lower. The same rule applies to packing in write mode and unpacking in read mode.
- R4: In read mode, the bridge requests words while fewer than NEAR_FULL (6) words are queued. It stops at 6, and it fetches again once a word has been consumed.
- R5: In read mode, `dreqN` is low exactly while the read queue holds a word. Each `rdTake` while `dreqN` is low consumes the byte shown on `rdByte`. A word leaves the queue after its eighth byte.
- R6: In write mode, `dreqN` is low while fewer than NEAR_FULL words are queued for writing. A byte strobed while `dreqN` is high is discarded.
- R7: In write mode, `memReq` is high with `memWe` high while a packed word is queued. Words are written to memory in the order they were completed.
- R8: `memAddr` starts at the loaded start address. It rises by one after each completed memory word.
- R9: A `modeWr` pulse empties both queues and discards any partly packed word.
- R10: After reset the mode is idle, `dreqN` is high and `memReq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWr | input | 1 | Load strobe for mode, start address and byte order |
| modeSel | input | 2 | Mode to load |
| startAddr | input | ADDR_W | Start word address to load |
| byteOrder | input | 1 | Byte lane order to load |
| dreqN | output | 1 | Active-low transfer request to the DMA engine |
| rdTake | input | 1 | DMA engine takes the byte on rdByte |
| rdByte | output | 8 | Next byte for the DMA engine in read mode |
| wrStrobe | input | 1 | DMA engine delivers wrByte |
| wrByte | input | 8 | Byte from the DMA engine in write mode |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | 64 | Memory write word |
| memAck | input | 1 | Memory completes the current word |
| memRdata | input | 64 | Memory read word, valid with memAck |

## Verification
The bench uses the default parameters: queue depth 8, near-full level 6 and a 16-bit address. With these values, a stalled memory fills a queue to its limit within 48 bytes. The 16-bit address allows a word to be placed at the highest address, 16'hFFFF. Holding back the memory acknowledge lets the bench see the request output at the near-full boundary. It also shows that a mode change throws away queued words before they reach memory.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  localparam int WORD_BYTES = 8;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int LANE_W     = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_READ  = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_BLOCK = 2'b11
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              flush;
    logic              rdPush;
    logic              rdPop;
    logic              byteLoad;
    logic              wrPush;
    logic              wrPop;
    logic [LANE_W-1:0] rdLane;
    logic [LANE_W-1:0] packLane;
  } strobe_t;
endpackage

// File: rtl/dbb_fifo.sv
module dbb_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        store[wrPtr] <= din;
        wrPtr <= bump(wrPtr);
      end
      if (pop) rdPtr <= bump(rdPtr);
      if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head = store[rdPtr];
endmodule

// File: rtl/dbb_ctrl.sv
module dbb_ctrl
  import dbb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NEAR_FULL = 6,
  parameter int ADDR_W    = 16,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic [1:0]        modeSel,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteOrder,
  input  logic              rdTake,
  input  logic              wrStrobe,
  input  logic              memAck,
  input  logic [CW-1:0]     rdCount,
  input  logic [CW-1:0]     wrCount,
  output strobe_t           stb,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              dreqN,
  output mode_e             curMode
);
  localparam logic [LANE_W-1:0] LAST = LANE_W'(WORD_BYTES - 1);

  logic              order;
  logic [LANE_W-1:0] rdIdx, packIdx;
  logic              reading, writing, rdAvail, rdRoom, wrRoom;
  logic              takeOk, loadOk, xfer;

  always_comb begin
    reading = (curMode == MODE_READ);
    writing = (curMode == MODE_WRITE);
    rdAvail = (rdCount != '0);
    rdRoom  = (rdCount < CW'(NEAR_FULL));
    wrRoom  = (wrCount < CW'(NEAR_FULL));
    memReq  = (reading && rdRoom) || (writing && (wrCount != '0));
    memWe   = writing;
    dreqN   = !((reading && rdAvail) || (writing && wrRoom));
    takeOk  = !modeWr && reading && rdAvail && rdTake;
    loadOk  = !modeWr && writing && wrRoom && wrStrobe;
    xfer    = !modeWr && memReq && memAck;

    stb.flush    = modeWr;
    stb.rdPush   = xfer && reading;
    stb.wrPop    = xfer && writing;
    stb.rdPop    = takeOk && (rdIdx == LAST);
    stb.byteLoad = loadOk;
    stb.wrPush   = loadOk && (packIdx == LAST);
    stb.rdLane   = order ? LAST - rdIdx : rdIdx;
    stb.packLane = order ? LAST - packIdx : packIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode <= MODE_IDLE;
      order   <= 1'b0;
      memAddr <= '0;
      rdIdx   <= '0;
      packIdx <= '0;
    end else if (modeWr) begin
      curMode <= mode_e'(modeSel);
      order   <= byteOrder;
      memAddr <= startAddr;
      rdIdx   <= '0;
      packIdx <= '0;
    end else begin
      if (xfer)   memAddr <= memAddr + 1'b1;
      if (takeOk) rdIdx   <= rdIdx + 1'b1;
      if (loadOk) packIdx <= packIdx + 1'b1;
    end
  end
endmodule

// File: rtl/dbb_datapath.sv
module dbb_datapath
  import dbb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        wrByte,
  input  logic [WORD_W-1:0] memRdata,
  output logic [7:0]        rdByte,
  output logic [WORD_W-1:0] memWdata,
  output logic [CW-1:0]     rdCount,
  output logic [CW-1:0]     wrCount
);
  logic [WORD_W-1:0] packReg, packNext, rdHead;

  always_comb begin
    packNext = packReg;
    packNext[{stb.packLane, 3'b000} +: 8] = wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.flush) packReg <= '0;
    else if (stb.byteLoad)  packReg <= packNext;
  end

  dbb_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rdq (
    .clk(clk), .rstN(rstN), .flush(stb.flush),
    .push(stb.rdPush), .din(memRdata), .pop(stb.rdPop),
    .head(rdHead), .count(rdCount)
  );

  dbb_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_wrq (
    .clk(clk), .rstN(rstN), .flush(stb.flush),
    .push(stb.wrPush), .din(packNext), .pop(stb.wrPop),
    .head(memWdata), .count(wrCount)
  );

  assign rdByte = rdHead[{stb.rdLane, 3'b000} +: 8];
endmodule

// File: rtl/dma_byte_bridge.sv
module dma_byte_bridge
  import dbb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NEAR_FULL = 6,
  parameter int ADDR_W    = 16,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic [1:0]        modeSel,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteOrder,
  output logic              dreqN,
  input  logic              rdTake,
  output logic [7:0]        rdByte,
  input  logic              wrStrobe,
  input  logic [7:0]        wrByte,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  input  logic              memAck,
  input  logic [63:0]       memRdata
);
  strobe_t       stb;
  mode_e         curMode;
  logic [CW-1:0] rdCount, wrCount;

  dbb_ctrl #(.DEPTH(DEPTH), .NEAR_FULL(NEAR_FULL), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeSel(modeSel),
    .startAddr(startAddr), .byteOrder(byteOrder), .rdTake(rdTake),
    .wrStrobe(wrStrobe), .memAck(memAck), .rdCount(rdCount),
    .wrCount(wrCount), .stb(stb), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .dreqN(dreqN), .curMode(curMode)
  );

  dbb_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(wrByte),
    .memRdata(memRdata), .rdByte(rdByte), .memWdata(memWdata),
    .rdCount(rdCount), .wrCount(wrCount)
  );
endmodule

// File: rtl/dbb_checker.sv
module dbb_checker #(
  parameter int DEPTH     = 8,
  parameter int NEAR_FULL = 6,
  parameter int ADDR_W    = 16,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeWr,
  input logic [1:0]        curMode,
  input logic              dreqN,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [CW-1:0]     rdCount,
  input logic [CW-1:0]     wrCount
);
  assert_idle_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b00 || curMode == 2'b11) |-> (dreqN && !memReq));

  assert_rd_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdCount <= CW'(NEAR_FULL));

  assert_rd_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b01 && !dreqN) |-> (rdCount != '0));

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b10 && wrCount >= CW'(NEAR_FULL)) |-> dreqN);

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !modeWr) |=> (memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> (rdCount == '0 && wrCount == '0));
endmodule

bind dma_byte_bridge dbb_checker #(.DEPTH(DEPTH), .NEAR_FULL(NEAR_FULL), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeWr(modeWr), .curMode(curMode), .dreqN(dreqN),
  .memReq(memReq), .memAck(memAck), .memAddr(memAddr),
  .rdCount(rdCount), .wrCount(wrCount)
);

// File: tb/tb_dma_byte_bridge.sv
module tb_dma_byte_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWr = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [15:0] startAddr = '0;
  logic        byteOrder = 1'b0;
  logic        dreqN;
  logic        rdTake = 1'b0;
  logic [7:0]  rdByte;
  logic        wrStrobe = 1'b0;
  logic [7:0]  wrByte = '0;
  logic        memReq, memWe;
  logic [15:0] memAddr;
  logic [63:0] memWdata;
  logic        memAck = 1'b0;
  logic [63:0] memRdata = '0;

  int  nRun = 0, nFail = 0;
  bit  done = 0;
  bit  ackEn = 0;
  int  logN = 0, rdAcks = 0;
  logic [15:0] logAddr [64];
  logic [63:0] logData [64];

  always #10 clk = ~clk;

  dma_byte_bridge dut (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeSel(modeSel),
    .startAddr(startAddr), .byteOrder(byteOrder), .dreqN(dreqN),
    .rdTake(rdTake), .rdByte(rdByte), .wrStrobe(wrStrobe), .wrByte(wrByte),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [63:0] pat(input logic [15:0] a);
    return {a, ~a, a + 16'h1234, a ^ 16'hC0DE};
  endfunction

  // memory model: acknowledge one cycle after a request, log completed words
  always @(posedge clk) begin
    if (memReq && memAck) begin
      if (memWe) begin
        logAddr[logN % 64] <= memAddr;
        logData[logN % 64] <= memWdata;
        logN <= logN + 1;
      end else rdAcks <= rdAcks + 1;
    end
    memAck   <= ackEn && memReq && !memAck;
    memRdata <= pat(memAddr);
  end

  typedef struct packed {
    logic        order;
    logic [15:0] addr;
    logic [7:0]  base;
    logic [63:0] expWord;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{1'b0, 16'h0010, 8'h01, 64'h0807060504030201},
    '{1'b1, 16'h0020, 8'h11, 64'h1112131415161718},
    '{1'b0, 16'hFFFF, 8'hA0, 64'hA7A6A5A4A3A2A1A0},
    '{1'b1, 16'h0000, 8'hF8, 64'hF8F9FAFBFCFDFEFF}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setMode(input logic [1:0] m, input logic [15:0] a, input logic o);
    @(negedge clk);
    modeSel = m; startAddr = a; byteOrder = o; modeWr = 1'b1;
    @(negedge clk);
    modeWr = 1'b0;
  endtask

  task automatic putByte(input logic [7:0] b);
    @(negedge clk);
    wrByte = b; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic takeByte(output logic [7:0] b);
    @(negedge clk);
    b = rdByte; rdTake = 1'b1;
    @(negedge clk);
    rdTake = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int s;
    logic [7:0]  b;
    logic [63:0] w, e;
    bit bad;

    idle(3);
    rstN = 1'b1;
    idle(1);
    check(dreqN == 1'b1, "R10 dreqN after reset", 64'(dreqN), 64'd1);
    check(memReq == 1'b0, "R10 memReq after reset", 64'(memReq), 64'd0);

    // vector walk: write packing in both byte orders
    ackEn = 1;
    foreach (VEC[i]) begin
      setMode(2'b10, VEC[i].addr, VEC[i].order);
      s = logN;
      for (int k = 0; k < 8; k++) putByte(VEC[i].base + 8'(k));
      idle(6);
      check(logN == s + 1, "R7 one word written", 64'(logN - s), 64'd1);
      check(logAddr[s % 64] == VEC[i].addr, "R1 start address", 64'(logAddr[s % 64]), 64'(VEC[i].addr));
      check(logData[s % 64] == VEC[i].expWord, "R3 packed word", logData[s % 64], VEC[i].expWord);
    end

    // idle mode ignores bytes
    setMode(2'b00, 16'h0500, 1'b0);
    s = logN;
    for (int k = 0; k < 8; k++) putByte(8'h33);
    idle(5);
    check(memReq == 1'b0 && logN == s, "R2 idle ignores bytes", 64'(logN - s), 64'd0);
    check(dreqN == 1'b1, "R2 idle dreqN", 64'(dreqN), 64'd1);

    // block move holds everything
    setMode(2'b11, 16'h0600, 1'b0);
    idle(5);
    check(dreqN == 1'b1 && memReq == 1'b0, "R2 block-move stalled", {dreqN, memReq}, 64'b10);

    // write near-full with a stalled memory
    ackEn = 0;
    idle(3);
    setMode(2'b10, 16'h0100, 1'b0);
    check(dreqN == 1'b0, "R6 write request open", 64'(dreqN), 64'd0);
    for (int k = 0; k < 48; k++) putByte(8'(k));
    check(dreqN == 1'b1, "R6 write request closed at near-full", 64'(dreqN), 64'd1);
    for (int k = 0; k < 8; k++) putByte(8'hEE);
    s = logN;
    ackEn = 1;
    idle(30);
    check(logN - s == 6, "R6 bytes beyond near-full dropped", 64'(logN - s), 64'd6);
    bad = 0;
    for (int k = 0; k < 6; k++) if (logAddr[(s + k) % 64] != 16'h0100 + 16'(k)) bad = 1;
    check(!bad, "R8 consecutive write addresses", 64'(bad), 64'd0);
    check(logData[(s + 5) % 64] == 64'h2F2E2D2C2B2A2928, "R7 last word in order", logData[(s + 5) % 64], 64'h2F2E2D2C2B2A2928);
    check(memReq == 1'b0, "R7 request drops when queue empty", 64'(memReq), 64'd0);

    // read mode prefetch
    s = rdAcks;
    setMode(2'b01, 16'h0040, 1'b0);
    idle(30);
    check(rdAcks - s == 6, "R4 prefetch stops at near-full", 64'(rdAcks - s), 64'd6);
    check(memReq == 1'b0, "R4 no request at near-full", 64'(memReq), 64'd0);
    check(dreqN == 1'b0, "R5 read request open", 64'(dreqN), 64'd0);
    w = '0;
    for (int k = 0; k < 8; k++) begin
      takeByte(b);
      w[k*8 +: 8] = b;
    end
    check(w == pat(16'h0040), "R5 first read word order 0", w, pat(16'h0040));
    idle(10);
    check(rdAcks - s == 7, "R4 refetch after consume", 64'(rdAcks - s), 64'd7);
    ackEn = 0;
    idle(3);
    bad = 0;
    for (int j = 0; j < 6; j++) begin
      w = '0;
      for (int k = 0; k < 8; k++) begin
        takeByte(b);
        w[k*8 +: 8] = b;
      end
      if (w != pat(16'h0041 + 16'(j))) bad = 1;
    end
    check(!bad, "R5 sequential read words", 64'(bad), 64'd0);
    check(dreqN == 1'b1, "R5 request closed when empty", 64'(dreqN), 64'd1);

    // read with byte order 1
    setMode(2'b01, 16'h0080, 1'b1);
    ackEn = 1;
    idle(20);
    w = '0;
    for (int k = 0; k < 8; k++) begin
      takeByte(b);
      w = {w[55:0], b};
    end
    check(w == pat(16'h0080), "R3 read unpack order 1", w, pat(16'h0080));

    // mode write drops a partial word
    ackEn = 0;
    idle(3);
    ackEn = 1;
    setMode(2'b10, 16'h0200, 1'b0);
    for (int k = 0; k < 3; k++) putByte(8'h55);
    setMode(2'b10, 16'h0300, 1'b0);
    s = logN;
    for (int k = 0; k < 8; k++) putByte(8'h60 + 8'(k));
    idle(6);
    e = 64'h6766656463626160;
    check(logN == s + 1 && logData[s % 64] == e, "R9 partial word discarded", logData[s % 64], e);
    check(logAddr[s % 64] == 16'h0300, "R9 new start address", 64'(logAddr[s % 64]), 64'h300);

    // mode write drops queued words
    ackEn = 0;
    idle(3);
    for (int k = 0; k < 16; k++) putByte(8'h77);
    setMode(2'b00, 16'h0000, 1'b0);
    s = logN;
    ackEn = 1;
    idle(10);
    check(logN == s && memReq == 1'b0, "R9 queued words flushed", 64'(logN - s), 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun + 1, nFail + 1);
      $finish;
    end
  end
endmodule